// File: doc/BRIEF.md
# Serial NOR Program and Erase Sequencer

This block carries out whole program and sector-erase jobs on a serial NOR flash. It works one byte at a time through a separate SPI shifter. A host pulses `start` with an operation select, a 24-bit start address and a byte count. The sequencer then builds every flash frame the job needs, with no further host help. It enables writes and waits on the status register until the flash is idle with its write-enable latch set. It then sends the command and address, and for a program it streams the host's bytes.

A long program is cut into separate frames wherever the running address reaches a 256-byte page boundary. At each cut the sequencer waits for the flash to go idle, enables writes again and resends the new address. Every job ends with a busy-clear wait and a write-disable. An erase walks through the range one 4 KB sector at a time. Each sector gets its own enable, erase, wait and disable. Requests that are not sector-aligned are refused.

The shifter side uses three request lines, all answered by one acknowledge: exchange a byte, drive chip select low, and release chip select. The byte received during an exchange comes back on `sh_rx`.

Top module: `nor_pe_seq`

## Requirements
- R1: Out of reset and between jobs, `busy`, `done`, `wr_ready` and all three shifter requests are low. At most one shifter request is active at a time, and it stays up until `sh_ack`.
- R2: Each job opens with a frame holding only 0x06. A status poll follows, and it must see (status & 0x03) == 0x02 before any program (0x02) or erase (0x20) frame is opened.
- R3: A program frame is 0x02 and an erase frame is 0x20. Either is followed by the three address bytes, bits 23:16 first and bits 7:0 last. Every frame ends with a chip-select release.
- R4: A program frame ends as soon as the next address would be a multiple of 256. The sequencer then polls for not-busy, sends 0x06, polls for (status & 0x03) == 0x02, and opens a new 0x02 frame at the new address.
- R5: After each program frame, erase frame and 0x04 frame, a status poll runs until status bit 0 reads 0. Status bits 7:2 are ignored by every poll, and no new command frame starts while the flash reports busy.
- R6: A status poll holds chip select low. It sends 0x05 once and then reads status bytes back to back. It releases chip select only after the byte that matched.
- R7: A program job ends with a frame holding only 0x04 and a busy-clear poll. After that, `done` pulses for one cycle with `err` low.
- R8: An erase job handles one 4 KB sector per step, each as enable, poll, 0x20 frame, busy poll, 0x04 and poll. The address advances by 4096 per step until the length is used up.
- R9: An erase whose address or length has a nonzero value in bits 11:0, or whose length is zero, gives a `done` pulse with `err` high and produces no shifter activity.
- R10: A program with a byte count of zero produces only the 0x06 frame, its poll, the 0x04 frame and its poll, and then completes.
- R11: `wr_ready` is high only while a data byte can be taken for a program frame. A program job consumes exactly its byte count from the host stream, and an erase consumes none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a job (taken when idle) |
| op_erase | input | 1 | 1 = sector erase, 0 = program |
| addr | input | 24 | Start address of the job |
| len | input | LEN_W | Byte count of the job |
| busy | output | 1 | A job is running |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request refused, valid with `done` |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | `wr_data` is valid |
| wr_ready | output | 1 | Sequencer takes `wr_data` this cycle |
| sh_xfer | output | 1 | Shifter: exchange one byte |
| sh_cs_lo | output | 1 | Shifter: drive chip select low |
| sh_cs_hi | output | 1 | Shifter: release chip select |
| sh_tx | output | 8 | Byte to send |
| sh_rx | input | 8 | Byte received, valid with `sh_ack` of an exchange |
| sh_ack | input | 1 | Shifter completed the request |

## Verification
Programs are run inside one page, ending exactly on a page boundary, crossing one boundary, and spanning more than a full page from offset zero. Together these separate a missing split, a split one byte late, and a spurious re-enable after the final byte. A zero-length program and a two-sector erase exercise the frame order without data and the per-sector address step. Three refused erases (misaligned address, misaligned length, zero length) must complete with the error flag and no traffic. The flash model reports busy for several status reads with an unrelated high bit set, so a poll that compares the wrong bits or leaves too early is caught.

// File: rtl/nor_pe_pkg.sv
package nor_pe_pkg;
    localparam int ADDR_W = 24;

    localparam logic [7:0] OP_WEN    = 8'h06;
    localparam logic [7:0] OP_WDI    = 8'h04;
    localparam logic [7:0] OP_RDSR   = 8'h05;
    localparam logic [7:0] OP_PROG   = 8'h02;
    localparam logic [7:0] OP_SERASE = 8'h20;

    typedef enum logic [1:0] {LK_XFER, LK_CSLO, LK_CSHI} lk_kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_CSL, S_BYTE, S_PRD, S_DATA, S_CSH, S_DONE
    } seq_st_e;

    typedef enum logic [1:0] {FR_WEN, FR_WDI, FR_CMD, FR_POLL} frame_e;
endpackage

// File: rtl/nor_pe_link.sv
module nor_pe_link
    import nor_pe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  lk_kind_e   kind,
    input  logic [7:0] tx,
    output logic       fin,
    output logic [7:0] rx,
    output logic       sh_xfer,
    output logic       sh_cs_lo,
    output logic       sh_cs_hi,
    output logic [7:0] sh_tx,
    input  logic [7:0] sh_rx,
    input  logic       sh_ack
);
    typedef struct packed {
        logic       busy;
        lk_kind_e   kind;
        logic [7:0] tx;
        logic       fin;
        logic [7:0] rx;
    } lk_t;

    lk_t q, d;

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        if (!q.busy && go) begin
            d.busy = 1'b1;
            d.kind = kind;
            d.tx   = tx;
        end
        if (q.busy && sh_ack) begin
            d.busy = 1'b0;
            d.fin  = 1'b1;
            d.rx   = sh_rx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{busy: 1'b0, kind: LK_XFER, tx: 8'h00, fin: 1'b0, rx: 8'h00};
        end else begin
            q <= d;
        end
    end

    assign fin      = q.fin;
    assign rx       = q.rx;
    assign sh_tx    = q.tx;
    assign sh_xfer  = q.busy && (q.kind == LK_XFER);
    assign sh_cs_lo = q.busy && (q.kind == LK_CSLO);
    assign sh_cs_hi = q.busy && (q.kind == LK_CSHI);
endmodule

// File: rtl/nor_pe_ctl.sv
module nor_pe_ctl
    import nor_pe_pkg::*;
#(
    parameter int LEN_W        = 16,
    parameter int PAGE_BYTES   = 256,
    parameter int SECTOR_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output logic              busy,
    output logic              done,
    output logic              err,
    input  logic [7:0]        wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic              lk_go,
    output lk_kind_e          lk_kind,
    output logic [7:0]        lk_tx,
    input  logic              lk_fin,
    input  logic [7:0]        lk_rx
);
    localparam int PG_W  = $clog2(PAGE_BYTES);
    localparam int SEC_W = $clog2(SECTOR_BYTES);
    localparam logic [ADDR_W-1:0] SEC_STEP = ADDR_W'(SECTOR_BYTES);
    localparam logic [LEN_W-1:0]  SEC_LEN  = LEN_W'(SECTOR_BYTES);

    typedef struct packed {
        seq_st_e           st;
        frame_e            fr;
        frame_e            pf;
        logic              pend;
        logic              erase;
        logic              err;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  cnt;
        logic [1:0]        idx;
        logic [7:0]        mask;
        logic [7:0]        val;
    } ctl_t;

    ctl_t q, d;
    logic [ADDR_W-1:0] addr_inc;
    logic [LEN_W-1:0]  cnt_dec;

    assign addr_inc = q.addr + 1'b1;
    assign cnt_dec  = q.cnt - 1'b1;

    always_comb begin
        d        = q;
        lk_go    = 1'b0;
        lk_kind  = LK_XFER;
        lk_tx    = 8'h00;
        wr_ready = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.addr  = addr;
                    d.cnt   = len;
                    d.erase = op_erase;
                    d.err   = 1'b0;
                    d.fr    = FR_WEN;
                    if (op_erase && (addr[SEC_W-1:0] != '0 ||
                                     len[SEC_W-1:0] != '0 || len == '0)) begin
                        d.err = 1'b1;
                        d.st  = S_DONE;
                    end else begin
                        d.st = S_CSL;
                    end
                end
            end
            S_CSL: begin
                lk_kind = LK_CSLO;
                if (!q.pend) begin
                    lk_go  = 1'b1;
                    d.pend = 1'b1;
                end else if (lk_fin) begin
                    d.pend = 1'b0;
                    d.idx  = 2'd0;
                    d.st   = S_BYTE;
                end
            end
            S_BYTE: begin
                case (q.fr)
                    FR_WEN:  lk_tx = OP_WEN;
                    FR_WDI:  lk_tx = OP_WDI;
                    FR_POLL: lk_tx = OP_RDSR;
                    default: begin
                        case (q.idx)
                            2'd0:    lk_tx = q.erase ? OP_SERASE : OP_PROG;
                            2'd1:    lk_tx = q.addr[23:16];
                            2'd2:    lk_tx = q.addr[15:8];
                            default: lk_tx = q.addr[7:0];
                        endcase
                    end
                endcase
                if (!q.pend) begin
                    lk_go  = 1'b1;
                    d.pend = 1'b1;
                end else if (lk_fin) begin
                    d.pend = 1'b0;
                    if (q.fr != FR_CMD || q.idx == 2'd3) begin
                        if (q.fr == FR_POLL) begin
                            d.st = S_PRD;
                        end else if (q.fr == FR_CMD && !q.erase) begin
                            d.st = S_DATA;
                        end else begin
                            d.st = S_CSH;
                            if (q.fr == FR_CMD) begin
                                d.addr = q.addr + SEC_STEP;
                                d.cnt  = q.cnt - SEC_LEN;
                            end
                        end
                    end else begin
                        d.idx = q.idx + 2'd1;
                    end
                end
            end
            S_PRD: begin
                if (!q.pend) begin
                    lk_go  = 1'b1;
                    d.pend = 1'b1;
                end else if (lk_fin) begin
                    d.pend = 1'b0;
                    if ((lk_rx & q.mask) == q.val) d.st = S_CSH;
                end
            end
            S_DATA: begin
                lk_tx    = wr_data;
                wr_ready = !q.pend;
                if (!q.pend) begin
                    if (wr_valid) begin
                        lk_go  = 1'b1;
                        d.pend = 1'b1;
                    end
                end else if (lk_fin) begin
                    d.pend = 1'b0;
                    d.addr = addr_inc;
                    d.cnt  = cnt_dec;
                    if (cnt_dec == '0 || addr_inc[PG_W-1:0] == '0) d.st = S_CSH;
                end
            end
            S_CSH: begin
                lk_kind = LK_CSHI;
                if (!q.pend) begin
                    lk_go  = 1'b1;
                    d.pend = 1'b1;
                end else if (lk_fin) begin
                    d.pend = 1'b0;
                    d.st   = S_CSL;
                    if (q.fr != FR_POLL) begin
                        d.pf   = q.fr;
                        d.fr   = FR_POLL;
                        d.mask = (q.fr == FR_WEN) ? 8'h03 : 8'h01;
                        d.val  = (q.fr == FR_WEN) ? 8'h02 : 8'h00;
                    end else begin
                        case (q.pf)
                            FR_WEN: d.fr = (!q.erase && q.cnt == '0) ? FR_WDI : FR_CMD;
                            FR_CMD: d.fr = (!q.erase && q.cnt != '0) ? FR_WEN : FR_WDI;
                            default: begin
                                if (q.erase && q.cnt != '0) d.fr = FR_WEN;
                                else                        d.st = S_DONE;
                            end
                        endcase
                    end
                end
            end
            S_DONE:  d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, fr: FR_WEN, pf: FR_WEN, pend: 1'b0, erase: 1'b0,
                   err: 1'b0, addr: '0, cnt: '0, idx: 2'd0, mask: 8'h00, val: 8'h00};
        end else begin
            q <= d;
        end
    end

    assign busy = (q.st != S_IDLE);
    assign done = (q.st == S_DONE);
    assign err  = (q.st == S_DONE) && q.err;
endmodule

// File: rtl/nor_pe_seq.sv
module nor_pe_seq
    import nor_pe_pkg::*;
#(
    parameter int LEN_W        = 16,
    parameter int PAGE_BYTES   = 256,
    parameter int SECTOR_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_erase,
    input  logic [23:0]       addr,
    input  logic [LEN_W-1:0]  len,
    output logic              busy,
    output logic              done,
    output logic              err,
    input  logic [7:0]        wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic              sh_xfer,
    output logic              sh_cs_lo,
    output logic              sh_cs_hi,
    output logic [7:0]        sh_tx,
    input  logic [7:0]        sh_rx,
    input  logic              sh_ack
);
    logic       lk_go;
    lk_kind_e   lk_kind;
    logic [7:0] lk_tx;
    logic       lk_fin;
    logic [7:0] lk_rx;

    nor_pe_ctl #(
        .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .SECTOR_BYTES(SECTOR_BYTES)
    ) ctl_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
        .addr(addr), .len(len), .busy(busy), .done(done), .err(err),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .lk_go(lk_go), .lk_kind(lk_kind), .lk_tx(lk_tx),
        .lk_fin(lk_fin), .lk_rx(lk_rx)
    );

    nor_pe_link link_i (
        .clk(clk), .rst_n(rst_n), .go(lk_go), .kind(lk_kind), .tx(lk_tx),
        .fin(lk_fin), .rx(lk_rx), .sh_xfer(sh_xfer), .sh_cs_lo(sh_cs_lo),
        .sh_cs_hi(sh_cs_hi), .sh_tx(sh_tx), .sh_rx(sh_rx), .sh_ack(sh_ack)
    );
endmodule

// File: rtl/nor_pe_chk.sv
module nor_pe_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic err,
    input logic wr_ready,
    input logic sh_xfer,
    input logic sh_cs_lo,
    input logic sh_cs_hi,
    input logic sh_ack
);
    // R1
    one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sh_xfer, sh_cs_lo, sh_cs_hi}));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(sh_xfer || sh_cs_lo || sh_cs_hi || wr_ready));

    // R1
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sh_xfer || sh_cs_lo || sh_cs_hi) && !sh_ack) |=>
            (sh_xfer || sh_cs_lo || sh_cs_hi));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R11
    ready_no_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (busy && !sh_cs_lo && !sh_cs_hi && !sh_xfer));
endmodule

bind nor_pe_seq nor_pe_chk chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
    .wr_ready(wr_ready), .sh_xfer(sh_xfer), .sh_cs_lo(sh_cs_lo),
    .sh_cs_hi(sh_cs_hi), .sh_ack(sh_ack)
);

// File: tb/nor_pe_seq_tb_top.sv
`timescale 1ns/1ps
module nor_pe_seq_tb_top;
    localparam int LEN_W = 16;
    localparam logic [8:0] END_MARK = 9'h100;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             op_erase = 1'b0;
    logic [23:0]      addr = '0;
    logic [LEN_W-1:0] len = '0;
    logic             busy, done, err;
    logic [7:0]       wr_data;
    logic             wr_valid;
    logic             wr_ready;
    logic             sh_xfer, sh_cs_lo, sh_cs_hi;
    logic [7:0]       sh_tx;
    logic [7:0]       sh_rx = 8'h00;
    logic             sh_ack = 1'b0;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    nor_pe_seq #(.LEN_W(LEN_W)) dut_i (.*);

    // scoreboard queues
    logic [8:0] exp_v[$];
    string      exp_r[$];

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'(a * 7 + 3);
    endfunction

    task automatic push(input logic [8:0] v, input string r);
        exp_v.push_back(v);
        exp_r.push_back(r);
    endtask

    task automatic push_one(input logic [7:0] op, input string r);
        push({1'b0, op}, r);
        push(END_MARK, r);
    endtask

    // host data stream
    int feed_cnt = 0;
    int feed_start = 0;
    int feed_base = 0;
    int feed_n = 0;
    int fidx;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (wr_valid && wr_ready) feed_cnt <= feed_cnt + 1;
    end

    always_comb begin
        fidx     = feed_cnt - feed_start;
        wr_valid = (fidx < feed_n) && (cyc % 3 != 1);
        wr_data  = pat(feed_base + fidx);
    end

    // flash model and monitor
    bit         cs_low = 0;
    bit         first = 0;
    bit         wel = 0;
    int         busy_n = 0;
    int         dly = 0;
    logic [7:0] cur_op = 8'h00;
    logic [7:0] prev_op = 8'h00;
    logic [7:0] last_st = 8'h00;

    task automatic sb_pop(input logic [8:0] v);
        logic [8:0] e;
        string r;
        if (exp_v.size() == 0) begin
            chk(1'b0, "R3 unexpected item", int'(v), -1);
        end else begin
            e = exp_v.pop_front();
            r = exp_r.pop_front();
            chk(e == v, r, int'(v), int'(e));
        end
    endtask

    always @(posedge clk) begin
        logic [7:0] st;
        if (!rst_n) begin
            sh_ack <= 1'b0;
        end else begin
            sh_ack <= 1'b0;
            if (!sh_ack && (sh_xfer || sh_cs_lo || sh_cs_hi)) begin
                if (dly < 1) begin
                    dly++;
                end else begin
                    dly = 0;
                    sh_ack <= 1'b1;
                    if (sh_cs_lo) begin
                        chk(!cs_low, "R6 cs low twice", 1, 0);
                        cs_low = 1;
                        first  = 1;
                    end else if (sh_cs_hi) begin
                        chk(cs_low, "R6 cs release without frame", 0, 1);
                        cs_low = 0;
                        sb_pop(END_MARK);
                        if (cur_op == 8'h05) begin
                            // R2 / R5: poll left only on a matching status
                            if (prev_op == 8'h06)
                                chk((last_st & 8'h03) == 8'h02, "R2 poll exit", last_st, 8'h02);
                            else
                                chk(last_st[0] == 1'b0, "R5 poll exit", last_st, 8'h00);
                        end else begin
                            prev_op = cur_op;
                            case (cur_op)
                                8'h06:        begin wel = 1; busy_n = 2; end
                                8'h02, 8'h20: begin wel = 0; busy_n = 4; end
                                8'h04:        begin wel = 0; busy_n = 2; end
                                default:      ;
                            endcase
                        end
                    end else begin
                        chk(cs_low, "R6 byte outside frame", 0, 1);
                        if (first) begin
                            first  = 0;
                            cur_op = sh_tx;
                            sh_rx <= 8'h00;
                            sb_pop({1'b0, sh_tx});
                            if (sh_tx != 8'h05)
                                chk(busy_n == 0, "R5 frame while busy", busy_n, 0);
                            if (sh_tx == 8'h02 || sh_tx == 8'h20)
                                chk(wel, "R2 command without latch", 0, 1);
                        end else if (cur_op == 8'h05) begin
                            st = {1'b1, 5'b0, wel, busy_n != 0};
                            sh_rx  <= st;
                            last_st = st;
                            if (busy_n > 0) busy_n--;
                        end else begin
                            sb_pop({1'b0, sh_tx});
                        end
                    end
                end
            end
        end
    end

    // driver
    task automatic run_op(input bit er, input int a, input int n, input bit exp_err);
        int rem, cur, chunk, sa;
        bit got;
        if (!exp_err) begin
            if (er) begin
                sa = a;
                for (int s = 0; s < n / 4096; s++) begin
                    push_one(8'h06, "R8");
                    push_one(8'h05, "R8");
                    push(9'h020, "R3");
                    push({1'b0, 8'(sa >> 16)}, "R3");
                    push({1'b0, 8'(sa >> 8)}, "R3");
                    push({1'b0, 8'(sa)}, "R3");
                    push(END_MARK, "R3");
                    push_one(8'h05, "R5");
                    push_one(8'h04, "R8");
                    push_one(8'h05, "R8");
                    sa += 4096;
                end
            end else begin
                push_one(8'h06, "R2");
                push_one(8'h05, "R2");
                rem = n;
                cur = a;
                while (rem > 0) begin
                    chunk = 256 - (cur % 256);
                    if (chunk > rem) chunk = rem;
                    push(9'h002, "R3");
                    push({1'b0, 8'(cur >> 16)}, "R3");
                    push({1'b0, 8'(cur >> 8)}, "R3");
                    push({1'b0, 8'(cur)}, "R3");
                    for (int i = 0; i < chunk; i++) push({1'b0, pat(cur + i)}, "R11");
                    push(END_MARK, "R4");
                    push_one(8'h05, "R5");
                    rem -= chunk;
                    cur += chunk;
                    if (rem > 0) begin
                        push_one(8'h06, "R4");
                        push_one(8'h05, "R4");
                    end
                end
                push_one(8'h04, n == 0 ? "R10" : "R7");
                push_one(8'h05, n == 0 ? "R10" : "R7");
            end
        end
        @(negedge clk);
        feed_base  = a;
        feed_start = feed_cnt;
        feed_n     = er ? 0 : n;
        start    = 1'b1;
        op_erase = er;
        addr     = 24'(a);
        len      = LEN_W'(n);
        @(negedge clk);
        start = 1'b0;
        got = 0;
        for (int i = 0; i < 40000 && !got; i++) begin
            if (done) got = 1;
            else @(negedge clk);
        end
        chk(got, "R7 done timeout", 0, 1);
        chk(err == exp_err, exp_err ? "R9 error flag" : "R7 error flag", err, exp_err);
        @(negedge clk);
        chk(!done && !busy, "R7 done single pulse", done, 0);
        chk(exp_v.size() == 0, exp_err ? "R9 missing traffic" : "R3 missing frames",
            exp_v.size(), 0);
        exp_v.delete();
        exp_r.delete();
        chk(feed_cnt - feed_start == feed_n, "R11 bytes consumed",
            feed_cnt - feed_start, feed_n);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !err && !wr_ready, "R1 idle outputs",
            {busy, done, err, wr_ready}, 0);
        chk(!sh_xfer && !sh_cs_lo && !sh_cs_hi, "R1 no shifter request",
            {sh_xfer, sh_cs_lo, sh_cs_hi}, 0);

        run_op(1'b0, 24'h001000, 5,   1'b0);   // inside one page
        run_op(1'b0, 24'h0000FC, 4,   1'b0);   // ends on boundary, R4 no extra enable
        run_op(1'b0, 24'h0120F0, 40,  1'b0);   // one split, R4
        run_op(1'b0, 24'h000000, 300, 1'b0);   // full page plus tail, R4
        run_op(1'b0, 24'h004000, 0,   1'b0);   // R10
        run_op(1'b1, 24'h003000, 8192, 1'b0);  // R8 two sectors
        run_op(1'b1, 24'h003100, 4096, 1'b1);  // R9 misaligned address
        run_op(1'b1, 24'h002000, 100,  1'b1);  // R9 misaligned length
        run_op(1'b1, 24'h002000, 0,    1'b1);  // R9 zero length
        run_op(1'b0, 24'h0FFFFE, 3,   1'b0);   // split near top of a block

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule